// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives a parallel RGB panel that runs on a dot clock. Each line is counted in pixel clocks and each frame in whole lines. From these two counters it makes a horizontal sync pulse, a vertical sync pulse, a data-enable window and a 24-bit pixel bus. The horizontal sync period and pulse width are programmed in pixel clocks. The vertical period and pulse width are programmed in complete lines. Inside each line, a wait count measured from the start of the line comes first. A separate valid-data count then sets how many pixels the line carries. The same split of wait count and active count applies to the lines of a frame.

Pixels come from an upstream stream with valid/ready and a start-of-frame flag. Ready is raised only at active pixel positions. Each accepted pixel appears on the panel bus one clock later. If the stream runs dry at an active position, filler (all zeros) goes out with the enable still asserted. With the recovery option set, the block stops taking pixels for the rest of that frame and keeps sending filler. It also discards stream words until a start-of-frame word arrives, then resumes at the next frame with the pixel alignment intact.

The controller has three states. IDLE holds every output inactive. RUN produces normal timing. DRAIN produces timing with filler data after an underflow while recovery is on. The transitions are:
- IDLE to RUN when sync generation is switched on.
- RUN to IDLE, and DRAIN to IDLE, when sync generation is switched off. This has the highest priority.
- RUN to DRAIN on a missing pixel at an active position with recovery on, unless that position is the last of the frame.
- DRAIN to RUN at the end of a frame.

Timing values are copied into shadow registers in IDLE and at each frame end. Polarity and enable-present settings act at once.

Top module: `rgbt_lcd_timing`

## Requirements
- R1: While reset is asserted, every sync and enable output sits at its inactive level, the data bus is zero and the pixel ready output is low.
- R2: A line lasts `h_period` clocks, and horizontal sync is asserted during its first `h_pulse` clocks.
- R3: A frame lasts `v_period` lines, and vertical sync is asserted for all clocks of its first `v_pulse` lines.
- R4: The enable output is asserted for line columns c with `h_wait` <= c < `h_wait`+`h_valid`, on frame lines l with `v_wait` <= l < `v_wait`+`v_active`. Line and column count from 0 at the start of the sync pulse. Every panel output shows a position one clock after the counters hold it.
- R5: In RUN, pixel ready is high exactly at active positions. A pixel accepted there appears on the data bus in the next clock. The data bus is zero at every other position.
- R6: Each of the three polarity inputs, when 1, makes its output active-high; when 0, active-low. A change takes effect immediately.
- R7: With `en_present` at 0, the enable output stays at its inactive level throughout.
- R8: Sync generation is controlled by `sync_on`. When it is sampled low, the outputs become inactive from the following clock. When it is raised again, the first position is line 0, column 0.
- R9: Timing inputs are copied into shadow registers only while in IDLE or at a frame end. A change in the middle of a frame takes effect from the next frame.
- R10: Recovery off: a missing pixel at an active position gives enable asserted with zero data. The next valid pixel is taken at the next active position.
- R11: Recovery on: after a missing pixel, every remaining active position of the frame carries zero data. Pixel ready is high at every position except while a word flagged start-of-frame is offered. Normal intake restarts in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (dot) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_on | input | 1 | Enables timing generation |
| recover_en | input | 1 | Underflow recovery option |
| en_present | input | 1 | Enable output used by the panel |
| hs_pol | input | 1 | Horizontal sync polarity (1 = active-high) |
| vs_pol | input | 1 | Vertical sync polarity (1 = active-high) |
| de_pol | input | 1 | Enable polarity (1 = active-high) |
| h_period | input | CW | Clocks per line |
| h_pulse | input | CW | Horizontal sync width in clocks |
| h_wait | input | CW | Clocks from line start to first pixel |
| h_valid | input | CW | Pixels per active line |
| v_period | input | CW | Lines per frame |
| v_pulse | input | CW | Vertical sync width in lines |
| v_wait | input | CW | Lines from frame start to first active line |
| v_active | input | CW | Active lines per frame |
| pix_valid | input | 1 | Upstream pixel valid |
| pix_data | input | DW | Upstream pixel word |
| pix_sof | input | 1 | Upstream start-of-frame flag |
| pix_ready | output | 1 | Pixel accepted this clock when valid |
| lcd_hsync | output | 1 | Horizontal sync to panel |
| lcd_vsync | output | 1 | Vertical sync to panel |
| lcd_de | output | 1 | Data enable to panel |
| lcd_data | output | DW | Pixel bus to panel |

## Verification
The hardest case to reach is the recovery path. To reach it, the stream must go dry at an active position while recovery is on. The block must then discard the rest of the frame's words and stop on a start-of-frame word exactly when the next frame begins. The stimulus gets there by restarting the raster from IDLE with a fresh word sequence. It then drops valid at a chosen active position, computed from the small configuration. The source keeps supplying the frame's remaining words at one per clock, so the flush finishes well before the frame end. A second configuration puts the last active pixel on the frame's final clock, so a line-end, frame-end and window coincidence is swept together with a mid-frame configuration change.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } rgbt_state_e;
endpackage

// File: rtl/rgbt_raster.sv
module rgbt_raster #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic [CW-1:0] cfg_hper,
    input  logic [CW-1:0] cfg_hpw,
    input  logic [CW-1:0] cfg_hwait,
    input  logic [CW-1:0] cfg_hval,
    input  logic [CW-1:0] cfg_vper,
    input  logic [CW-1:0] cfg_vpw,
    input  logic [CW-1:0] cfg_vwait,
    input  logic [CW-1:0] cfg_vact,
    output logic [CW-1:0] hcnt,
    output logic [CW-1:0] sh_hper,
    output logic          in_hs,
    output logic          in_vs,
    output logic          win,
    output logic          frame_end
);
    localparam int SW = CW + 1;

    logic [CW-1:0] vcnt;
    logic [CW-1:0] sh_hpw, sh_hwait, sh_hval, sh_vper, sh_vpw, sh_vwait, sh_vact;
    logic [SW-1:0] h_next, v_next, h_stop, v_stop;
    logic          line_end, reload;

    always_comb begin
        h_next    = {1'b0, hcnt} + SW'(1);
        v_next    = {1'b0, vcnt} + SW'(1);
        h_stop    = {1'b0, sh_hwait} + {1'b0, sh_hval};
        v_stop    = {1'b0, sh_vwait} + {1'b0, sh_vact};
        line_end  = h_next >= {1'b0, sh_hper};
        frame_end = running && line_end && (v_next >= {1'b0, sh_vper});
        reload    = !running || frame_end;
        in_hs     = hcnt < sh_hpw;
        in_vs     = vcnt < sh_vpw;
        win       = (hcnt >= sh_hwait) && ({1'b0, hcnt} < h_stop) &&
                    (vcnt >= sh_vwait) && ({1'b0, vcnt} < v_stop);
    end

    // shadow copy: only between frames or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hper <= '0; sh_hpw <= '0; sh_hwait <= '0; sh_hval <= '0;
            sh_vper <= '0; sh_vpw <= '0; sh_vwait <= '0; sh_vact <= '0;
        end else if (reload) begin
            sh_hper <= cfg_hper; sh_hpw <= cfg_hpw; sh_hwait <= cfg_hwait; sh_hval <= cfg_hval;
            sh_vper <= cfg_vper; sh_vpw <= cfg_vpw; sh_vwait <= cfg_vwait; sh_vact <= cfg_vact;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= v_next[CW-1:0];
        end else begin
            hcnt <= h_next[CW-1:0];
        end
    end
endmodule

// File: rtl/rgbt_ctrl.sv
module rgbt_ctrl
    import rgbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sync_on,
    input  logic        recover_en,
    input  logic        win,
    input  logic        frame_end,
    input  logic        pix_valid,
    input  logic        pix_sof,
    output rgbt_state_e st_q,
    output logic        pix_ready,
    output logic        take
);
    rgbt_state_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (sync_on) st_d = ST_RUN;
            ST_RUN: begin
                if (!sync_on)
                    st_d = ST_IDLE;
                else if (win && !pix_valid && recover_en && !frame_end)
                    st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!sync_on)       st_d = ST_IDLE;
                else if (frame_end) st_d = ST_RUN;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pix_ready = 1'b0;
        take      = 1'b0;
        unique case (st_q)
            ST_IDLE:  pix_ready = 1'b0;
            ST_RUN: begin
                pix_ready = win;
                take      = win && pix_valid;
            end
            ST_DRAIN: pix_ready = !(pix_valid && pix_sof);
            default:  pix_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/rgbt_outreg.sv
module rgbt_outreg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          in_hs,
    input  logic          in_vs,
    input  logic          win,
    input  logic          take,
    input  logic [DW-1:0] pix_data,
    input  logic          en_present,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          de_pol,
    output logic          hs_raw,
    output logic          vs_raw,
    output logic          de_raw,
    output logic [DW-1:0] data_raw,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic [DW-1:0] lcd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_raw   <= 1'b0;
            vs_raw   <= 1'b0;
            de_raw   <= 1'b0;
            data_raw <= '0;
        end else begin
            hs_raw   <= live && in_hs;
            vs_raw   <= live && in_vs;
            de_raw   <= live && win;
            data_raw <= take ? pix_data : '0;
        end
    end

    always_comb begin
        lcd_hsync = hs_pol ? hs_raw : !hs_raw;
        lcd_vsync = vs_pol ? vs_raw : !vs_raw;
        lcd_de    = de_pol ? (de_raw && en_present) : !(de_raw && en_present);
        lcd_data  = data_raw;
    end
endmodule

// File: rtl/rgbt_lcd_timing.sv
module rgbt_lcd_timing
    import rgbt_pkg::*;
#(
    parameter int CW = 12,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_on,
    input  logic          recover_en,
    input  logic          en_present,
    input  logic          hs_pol,
    input  logic          vs_pol,
    input  logic          de_pol,
    input  logic [CW-1:0] h_period,
    input  logic [CW-1:0] h_pulse,
    input  logic [CW-1:0] h_wait,
    input  logic [CW-1:0] h_valid,
    input  logic [CW-1:0] v_period,
    input  logic [CW-1:0] v_pulse,
    input  logic [CW-1:0] v_wait,
    input  logic [CW-1:0] v_active,
    input  logic          pix_valid,
    input  logic [DW-1:0] pix_data,
    input  logic          pix_sof,
    output logic          pix_ready,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic [DW-1:0] lcd_data
);
    rgbt_state_e   st_q;
    logic          live, in_hs, in_vs, win, frame_end, take;
    logic          hs_raw, vs_raw, de_raw;
    logic [DW-1:0] data_raw;
    logic [CW-1:0] hcnt, sh_hper;

    assign live = (st_q != ST_IDLE);

    rgbt_raster #(.CW(CW)) raster_i (
        .clk(clk), .rst_n(rst_n), .running(live),
        .cfg_hper(h_period), .cfg_hpw(h_pulse), .cfg_hwait(h_wait), .cfg_hval(h_valid),
        .cfg_vper(v_period), .cfg_vpw(v_pulse), .cfg_vwait(v_wait), .cfg_vact(v_active),
        .hcnt(hcnt), .sh_hper(sh_hper), .in_hs(in_hs), .in_vs(in_vs),
        .win(win), .frame_end(frame_end)
    );

    rgbt_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .sync_on(sync_on), .recover_en(recover_en),
        .win(win), .frame_end(frame_end), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .st_q(st_q), .pix_ready(pix_ready), .take(take)
    );

    rgbt_outreg #(.DW(DW)) outreg_i (
        .clk(clk), .rst_n(rst_n), .live(live), .in_hs(in_hs), .in_vs(in_vs),
        .win(win), .take(take), .pix_data(pix_data), .en_present(en_present),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol),
        .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw), .data_raw(data_raw),
        .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .lcd_data(lcd_data)
    );
endmodule

// File: rtl/rgbt_lcd_timing_chk.sv
module rgbt_lcd_timing_chk
    import rgbt_pkg::*;
#(
    parameter int CW = 12,
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input rgbt_state_e   st,
    input logic          win,
    input logic          frame_end,
    input logic          pix_ready,
    input logic          hs_raw,
    input logic          vs_raw,
    input logic          de_raw,
    input logic [DW-1:0] data_raw,
    input logic [CW-1:0] hcnt,
    input logic [CW-1:0] sh_hper
);
    a_r5_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && pix_ready) |-> win);

    a_r4_enable_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && win) |=> de_raw);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (!hs_raw && !vs_raw && !de_raw));

    a_r11_drain_filler: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN) |=> (data_raw == '0));

    a_r9_shadow_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !frame_end) |=> $stable(sh_hper));

    a_r2_column_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && sh_hper != '0) |-> (hcnt < sh_hper));
endmodule

bind rgbt_lcd_timing rgbt_lcd_timing_chk #(.CW(CW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .st(st_q), .win(win), .frame_end(frame_end),
    .pix_ready(pix_ready), .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw),
    .data_raw(data_raw), .hcnt(hcnt), .sh_hper(sh_hper)
);

// File: tb/rgbt_lcd_timing_tb_top.sv
`timescale 1ns/100ps
module rgbt_lcd_timing_tb_top;
    localparam int CW = 12;
    localparam int DW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic sync_on = 1'b0, recover_en = 1'b0, en_present = 1'b1;
    logic hs_pol = 1'b0, vs_pol = 1'b0, de_pol = 1'b1;
    logic [CW-1:0] h_period = '0, h_pulse = '0, h_wait = '0, h_valid = '0;
    logic [CW-1:0] v_period = '0, v_pulse = '0, v_wait = '0, v_active = '0;
    logic          pix_valid = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic          pix_sof = 1'b0;
    logic          pix_ready, lcd_hsync, lcd_vsync, lcd_de;
    logic [DW-1:0] lcd_data;

    rgbt_lcd_timing #(.CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_on(sync_on), .recover_en(recover_en),
        .en_present(en_present), .hs_pol(hs_pol), .vs_pol(vs_pol), .de_pol(de_pol),
        .h_period(h_period), .h_pulse(h_pulse), .h_wait(h_wait), .h_valid(h_valid),
        .v_period(v_period), .v_pulse(v_pulse), .v_wait(v_wait), .v_active(v_active),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof),
        .pix_ready(pix_ready), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_de(lcd_de), .lcd_data(lcd_data)
    );

    int    n_vec = 0, n_bad = 0;
    bit    done = 0;
    string phase = "R1 reset";

    // reference model state
    int m_st = 0, m_h = 0, m_v = 0;
    int s_hp = 0, s_hpw = 0, s_hw = 0, s_hv = 0, s_vp = 0, s_vpw = 0, s_vw = 0, s_va = 0;
    bit e_hs = 0, e_vs = 0, e_de = 0;
    logic [DW-1:0] e_data = '0;

    // source
    bit src_on = 1;
    int seq = 0;
    int src_fp = 15;
    bit fire_prev = 0;

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) act=%0b exp=%0b", tag, phase, act, exp);
        end
    endtask

    task automatic chkd(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) act=%0h exp=%0h", tag, phase, act, exp);
        end
    endtask

    task automatic set_cfg(input int hp, input int hpw, input int hw, input int hv,
                           input int vp, input int vpw, input int vw, input int va);
        h_period = CW'(hp); h_pulse = CW'(hpw); h_wait = CW'(hw); h_valid = CW'(hv);
        v_period = CW'(vp); v_pulse = CW'(vpw); v_wait = CW'(vw); v_active = CW'(va);
    endtask

    // called at a falling edge; ends at the next falling edge
    task automatic cycle();
        bit live, ins_hs, ins_vs, win, lend, fend, exp_ready, de_on;
        int nst;
        if (fire_prev) seq++;
        pix_valid = src_on;
        pix_data  = DW'(32'hA50000 | (seq & 32'hFFFF));
        pix_sof   = ((seq % src_fp) == 0);
        #1;
        chk1("R2 hsync", lcd_hsync, hs_pol ? e_hs : !e_hs);
        chk1("R3 vsync", lcd_vsync, vs_pol ? e_vs : !e_vs);
        de_on = e_de && en_present;
        if (en_present) chk1("R4 enable", lcd_de, de_pol ? de_on : !de_on);
        else            chk1("R7 enable", lcd_de, de_pol ? de_on : !de_on);
        chkd("R5 data", lcd_data, e_data);

        live   = (m_st != 0);
        ins_hs = (m_h < s_hpw);
        ins_vs = (m_v < s_vpw);
        win    = (m_h >= s_hw) && (m_h < s_hw + s_hv) && (m_v >= s_vw) && (m_v < s_vw + s_va);
        exp_ready = (m_st == 1) ? win : (m_st == 2) ? !(pix_valid && pix_sof) : 1'b0;
        chk1("R5 ready", pix_ready, exp_ready);
        fire_prev = pix_valid && exp_ready;

        e_hs   = live && ins_hs;
        e_vs   = live && ins_vs;
        e_de   = live && win;
        e_data = (m_st == 1 && win && pix_valid) ? pix_data : '0;

        lend = (m_h + 1 >= s_hp);
        fend = live && lend && (m_v + 1 >= s_vp);
        case (m_st)
            0: nst = sync_on ? 1 : 0;
            1: nst = !sync_on ? 0 : (win && !pix_valid && recover_en && !fend) ? 2 : 1;
            default: nst = !sync_on ? 0 : fend ? 1 : 2;
        endcase
        if (!live || fend) begin
            m_h = 0; m_v = 0;
            s_hp = int'(h_period); s_hpw = int'(h_pulse); s_hw = int'(h_wait); s_hv = int'(h_valid);
            s_vp = int'(v_period); s_vpw = int'(v_pulse); s_vw = int'(v_wait); s_va = int'(v_active);
        end else if (lend) begin
            m_h = 0; m_v++;
        end else begin
            m_h++;
        end
        m_st = nst;
        @(negedge clk);
    endtask

    initial begin
        set_cfg(12, 2, 4, 5, 8, 2, 3, 3);
        // R1: reset values
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk1("R1 hsync", lcd_hsync, 1'b1);
            chk1("R1 vsync", lcd_vsync, 1'b1);
            chk1("R1 enable", lcd_de, 1'b0);
            chkd("R1 data", lcd_data, '0);
            chk1("R1 ready", pix_ready, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) cycle();

        phase = "R2 R3 R4 R5 base";
        sync_on = 1'b1;
        repeat (3 * 96 + 5) cycle();

        phase = "R6 polarity";
        hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b0;
        repeat (96) cycle();
        phase = "R7 enable absent";
        en_present = 1'b0;
        repeat (96) cycle();
        en_present = 1'b1; hs_pol = 1'b0; vs_pol = 1'b0; de_pol = 1'b1;

        phase = "R9 reload at frame";
        repeat (30) cycle();
        set_cfg(7, 1, 1, 6, 5, 1, 0, 5);
        repeat (150) cycle();
        set_cfg(12, 2, 4, 5, 8, 2, 3, 3);
        repeat (200) cycle();

        phase = "R8 sync off";
        sync_on = 1'b0;
        repeat (10) cycle();
        seq = 0;
        sync_on = 1'b1;
        repeat (200) cycle();

        phase = "R10 slip";
        repeat (40) cycle();
        src_on = 1'b0;
        repeat (10) cycle();
        src_on = 1'b1;
        repeat (200) cycle();

        phase = "R11 recovery";
        sync_on = 1'b0;
        repeat (3) cycle();
        seq = 0;
        recover_en = 1'b1;
        sync_on = 1'b1;
        repeat (54) cycle();   // next position: line 4, column 5 (active)
        src_on = 1'b0;
        repeat (2) cycle();
        src_on = 1'b1;
        repeat (3 * 96) cycle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (%s) act=running exp=finished", phase);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule